// File: doc/BRIEF.md
# Double-Buffered PWM and Capture Timer with Fault Override

This block is a 16-bit general-purpose timer. The counter advances on a tick. The tick comes from one of four sources: the system clock, the rising edge of an external event input, a prescaled match pulse from a neighbouring timer, or no source (stopped). Two compare values set the waveform. Compare 0 is the cycle limit, at which the counter returns to zero. Compare 1 is the duty threshold used in PWM mode. Both compare values are written into shadow registers and only become active at a period boundary, so the period and duty can change while the timer runs without a glitch.

A capture input is synchronized, and on a selected edge the counter value is latched. The newest capture goes into capture slot 0 and the value it replaces moves to slot 1. An asynchronous active-low fault input is synchronized too. On its falling edge the pin is forced to a programmed level: driven high, driven low, or released (output enable low). The forced level holds until software clears it. Two registered interrupt pulses report the period wrap and each capture.

Top module: `pwm_cap_timer`

## Requirements
- R1: After synchronous reset the counter, both capture slots, both interrupt pulses and the override flag are 0, the pin data is 0 and the output enable is 1.
- R2: On each tick the counter increments. On a tick where it equals the active cycle limit it becomes 0 instead, and `irq_period` is high for exactly the following cycle.
- R3: A write on `cmp_wr[i]` updates only shadow register i. Both shadow values are copied to the active registers on a wrapping tick, so the active cycle and duty never change in the middle of a period.
- R4: With `mode_pwm`=1 and no override, the pin data is 1 exactly while the counter is below the active duty value. A duty of 0 gives a constant low and a duty above the cycle gives a constant high.
- R5: With `mode_pwm`=0 and no override, the pin data toggles after every wrapping tick.
- R6: `clk_src` selects the tick: 0 every clock, 1 the rising edge of `ev_in` after a two-flop synchronizer, 2 every Nth `peer_match` pulse with `peer_div` 0/1/2/3 giving N = 1/2/4/16, 3 no tick.
- R7: `cap_edge` selects the capture trigger on the synchronized `cap_in`: 0 none, 1 rising, 2 falling, 3 both. On a trigger, `cap0` takes the counter value, `cap1` takes the previous `cap0`, and `irq_capture` pulses for one cycle.
- R8: A falling edge of the synchronized `fault_n` while `ovr_sel` is non-zero latches the override: 1 drives data high, 2 drives data low, 3 sets `tmr_oe` low. With `ovr_sel`=0 the edge is ignored. The override holds until `ovr_clr`, and a fault edge in the same cycle as a clear takes priority.
- R9: While `run` is low the counter and the waveform state stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counting enable |
| mode_pwm | input | 1 | 1 = PWM, 0 = square wave |
| clk_src | input | 2 | Tick source select |
| peer_div | input | 2 | Divider for the peer match pulse |
| ev_in | input | 1 | Asynchronous external event input |
| peer_match | input | 1 | Match pulse from the neighbouring timer |
| cmp_wr | input | 2 | Write strobes for the two shadow compare registers |
| cmp_wdata | input | 16 | Compare write data |
| cap_edge | input | 2 | Capture edge select |
| cap_in | input | 1 | Asynchronous capture input |
| fault_n | input | 1 | Asynchronous active-low fault input |
| ovr_sel | input | 2 | Override level select |
| ovr_clr | input | 1 | Clears the latched override |
| tmr_cnt | output | 16 | Current counter value |
| tmr_out | output | 1 | Pin data |
| tmr_oe | output | 1 | Pin output enable |
| ovr_active | output | 1 | Override latched |
| cap0 | output | 16 | Newest captured value |
| cap1 | output | 16 | Previous captured value |
| irq_period | output | 1 | Period wrap interrupt pulse |
| irq_capture | output | 1 | Capture interrupt pulse |

## Verification
A corrupted counter or active compare register shows on `tmr_cnt` at the next tick, and on the pin within one period at the latest, because the wrap point or the duty edge moves. A shadow value loaded at the wrong moment changes the period length or the duty in the very period it was written, and a per-cycle reference model flags that on the next cycle. Faults in the synchronizers, the edge selection or the override latch surface one to three cycles after the input edge: a capture slot, an interrupt pulse or the pin enable disagrees with the model.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;
    localparam int PRE_W = 4;

    typedef enum logic [1:0] {SRC_SYS, SRC_EXT, SRC_PEER, SRC_OFF} src_e;
    typedef enum logic [1:0] {OVR_NONE, OVR_HIGH, OVR_LOW, OVR_HIZ} ovr_e;
    typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_BOTH} cap_edge_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Terminal count of the peer prescaler for the selected divide ratio.
    function automatic logic [PRE_W-1:0] peer_limit(input logic [1:0] div);
        case (div)
            2'd0:    return PRE_W'(0);
            2'd1:    return PRE_W'(1);
            2'd2:    return PRE_W'(3);
            default: return PRE_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/pct_sync.sv
`timescale 1ns/1ps
module pct_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          d,
    output pct_pkg::edge_t edg
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){RST_VAL}};
        else     chain <= {chain[STAGES-1:0], d};
    end

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    assign edg.rise = chain[STAGES-1] & ~chain[STAGES];
    assign edg.fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/pct_tick_gen.sv
`timescale 1ns/1ps
module pct_tick_gen
    import pct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  src_e       src,
    input  logic [1:0] peer_div,
    input  logic       ev_rise,
    input  logic       peer_match,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             pre_hit;

    assign lim     = peer_limit(peer_div);
    assign pre_hit = (pre_q >= lim);

    always_ff @(posedge clk) begin
        if (rst)             pre_q <= '0;
        else if (peer_match) pre_q <= pre_hit ? '0 : pre_q + 1'b1;
    end

    always_comb begin
        case (src)
            SRC_SYS:  tick = run;
            SRC_EXT:  tick = run & ev_rise;
            SRC_PEER: tick = run & peer_match & pre_hit;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/pct_counter.sv
`timescale 1ns/1ps
module pct_counter #(
    parameter int CNT_W = 16,
    parameter int N_CMP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             mode_pwm,
    input  logic [N_CMP-1:0] cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wave,
    output logic             irq_wrap
);
    logic [CNT_W-1:0] shadow [N_CMP];
    logic [CNT_W-1:0] active [N_CMP];
    logic             wrap;
    logic             tog_q;

    assign wrap = tick && (cnt == active[0]);

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[i] <= '0;
                active[i] <= '0;
            end else begin
                if (cmp_wr[i]) shadow[i] <= cmp_wdata;
                if (wrap)      active[i] <= shadow[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            tog_q    <= 1'b0;
            irq_wrap <= 1'b0;
        end else begin
            irq_wrap <= wrap;
            if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap && !mode_pwm) tog_q <= ~tog_q;
        end
    end

    assign wave = mode_pwm ? (cnt < active[1]) : tog_q;
endmodule

// File: rtl/pct_capture.sv
`timescale 1ns/1ps
module pct_capture
    import pct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_t            edg,
    input  cap_edge_e        sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1,
    output logic             irq
);
    logic trig;

    assign trig = (edg.rise && (sel == EDGE_RISE || sel == EDGE_BOTH)) ||
                  (edg.fall && (sel == EDGE_FALL || sel == EDGE_BOTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cap0 <= '0;
            cap1 <= '0;
            irq  <= 1'b0;
        end else begin
            irq <= trig;
            if (trig) begin
                cap1 <= cap0;
                cap0 <= cnt;
            end
        end
    end
endmodule

// File: rtl/pct_override.sv
`timescale 1ns/1ps
module pct_override
    import pct_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fault_fall,
    input  ovr_e  sel,
    input  logic  clr,
    input  logic  wave,
    output logic  pin,
    output logic  oe,
    output logic  active
);
    ovr_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            state_q <= OVR_NONE;
        end else if (fault_fall && sel != OVR_NONE) begin
            active  <= 1'b1;
            state_q <= sel;
        end else if (clr) begin
            active  <= 1'b0;
        end
    end

    always_comb begin
        pin = wave;
        oe  = 1'b1;
        if (active) begin
            pin = (state_q == OVR_HIGH);
            oe  = (state_q != OVR_HIZ);
        end
    end
endmodule

// File: rtl/pwm_cap_timer.sv
`timescale 1ns/1ps
module pwm_cap_timer
    import pct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             mode_pwm,
    input  logic [1:0]       clk_src,
    input  logic [1:0]       peer_div,
    input  logic             ev_in,
    input  logic             peer_match,
    input  logic [1:0]       cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       cap_edge,
    input  logic             cap_in,
    input  logic             fault_n,
    input  logic [1:0]       ovr_sel,
    input  logic             ovr_clr,
    output logic [CNT_W-1:0] tmr_cnt,
    output logic             tmr_out,
    output logic             tmr_oe,
    output logic             ovr_active,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1,
    output logic             irq_period,
    output logic             irq_capture
);
    edge_t ev_e, cap_e, flt_e;
    logic  tick;
    logic  wave;

    pct_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_ev_sync  (.clk, .rst, .d(ev_in),   .edg(ev_e));
    pct_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_cap_sync (.clk, .rst, .d(cap_in),  .edg(cap_e));
    pct_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_flt_sync (.clk, .rst, .d(fault_n), .edg(flt_e));

    pct_tick_gen u_tick (
        .clk, .rst, .run,
        .src(src_e'(clk_src)), .peer_div,
        .ev_rise(ev_e.rise), .peer_match,
        .tick
    );

    pct_counter #(.CNT_W(CNT_W), .N_CMP(2)) u_cnt (
        .clk, .rst, .tick, .mode_pwm, .cmp_wr, .cmp_wdata,
        .cnt(tmr_cnt), .wave, .irq_wrap(irq_period)
    );

    pct_capture #(.CNT_W(CNT_W)) u_cap (
        .clk, .rst, .edg(cap_e), .sel(cap_edge_e'(cap_edge)),
        .cnt(tmr_cnt), .cap0, .cap1, .irq(irq_capture)
    );

    pct_override u_ovr (
        .clk, .rst, .fault_fall(flt_e.fall), .sel(ovr_e'(ovr_sel)),
        .clr(ovr_clr), .wave, .pin(tmr_out), .oe(tmr_oe), .active(ovr_active)
    );
endmodule

// File: rtl/pct_checker.sv
`timescale 1ns/1ps
module pct_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             ovr_clr,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic             tmr_oe,
    input logic             ovr_active,
    input logic [CNT_W-1:0] cap0,
    input logic [CNT_W-1:0] cap1,
    input logic             irq_period,
    input logic             irq_capture
);
    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
        irq_period |-> tmr_cnt == '0);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tmr_cnt != $past(tmr_cnt)) |-> (tmr_cnt == CNT_W'($past(tmr_cnt) + 1'b1) || tmr_cnt == '0));

    assert_cap_shift_R7: assert property (@(posedge clk) disable iff (rst)
        irq_capture |-> cap1 == $past(cap0));

    assert_hiz_only_forced_R8: assert property (@(posedge clk) disable iff (rst)
        !tmr_oe |-> ovr_active);

    assert_override_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr_active && !ovr_clr) |=> ovr_active);

    assert_frozen_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(tmr_cnt));
endmodule

bind pwm_cap_timer pct_checker #(.CNT_W(CNT_W)) u_pct_checker (
    .clk, .rst, .run, .ovr_clr, .tmr_cnt, .tmr_oe, .ovr_active,
    .cap0, .cap1, .irq_period, .irq_capture
);

// File: tb/pwm_cap_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_cap_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 0, mode_pwm = 0, ev_in = 0, peer_match = 0, cap_in = 0;
    logic        fault_n = 1, ovr_clr = 0;
    logic [1:0]  clk_src = 0, peer_div = 0, cmp_wr = 0, cap_edge = 0, ovr_sel = 0;
    logic [15:0] cmp_wdata = 0;
    logic [15:0] tmr_cnt, cap0, cap1;
    logic        tmr_out, tmr_oe, ovr_active, irq_period, irq_capture;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R2";

    always #4 clk = ~clk;

    pwm_cap_timer dut_i (.*);

    // reference model state
    int m_cnt, m_sh0, m_sh1, m_a0, m_a1, m_tog, m_pre, m_c0, m_c1, m_ovr, m_st;
    int m_irqp, m_irqc;
    bit [2:0] m_ev, m_cp, m_fl;

    function automatic int lim_of(input int d);
        return (d == 0) ? 0 : (d == 1) ? 1 : (d == 2) ? 3 : 15;
    endfunction

    function automatic int exp_pin();
        if (m_ovr != 0) return (m_st == 1) ? 1 : 0;
        if (mode_pwm) return (m_cnt < m_a1) ? 1 : 0;
        return m_tog;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_sh0 = 0; m_sh1 = 0; m_a0 = 0; m_a1 = 0; m_tog = 0; m_pre = 0;
        m_c0 = 0; m_c1 = 0; m_ovr = 0; m_st = 0; m_irqp = 0; m_irqc = 0;
        m_ev = 3'b000; m_cp = 3'b000; m_fl = 3'b111;
    endtask

    task automatic model_step();
        bit ev_r, cp_r, cp_f, fl_f, tick, wrap, trig;
        int lim;
        ev_r = m_ev[1] & ~m_ev[2];
        cp_r = m_cp[1] & ~m_cp[2];
        cp_f = ~m_cp[1] & m_cp[2];
        fl_f = ~m_fl[1] & m_fl[2];
        lim  = lim_of(peer_div);
        case (clk_src)
            2'd0: tick = run;
            2'd1: tick = run & ev_r;
            2'd2: tick = run & peer_match & (m_pre >= lim);
            default: tick = 0;
        endcase
        if (peer_match) m_pre = (m_pre >= lim) ? 0 : m_pre + 1;
        wrap = tick && (m_cnt == m_a0);
        trig = (cp_r && cap_edge[0]) || (cp_f && cap_edge[1]);
        m_irqp = wrap;
        m_irqc = trig;
        if (trig) begin m_c1 = m_c0; m_c0 = m_cnt; end
        if (tick) m_cnt = wrap ? 0 : m_cnt + 1;
        if (wrap && !mode_pwm) m_tog ^= 1;
        if (wrap) begin m_a0 = m_sh0; m_a1 = m_sh1; end
        if (cmp_wr[0]) m_sh0 = cmp_wdata;
        if (cmp_wr[1]) m_sh1 = cmp_wdata;
        if (fl_f && ovr_sel != 0) begin m_ovr = 1; m_st = ovr_sel; end
        else if (ovr_clr) m_ovr = 0;
        m_ev = {m_ev[1:0], ev_in};
        m_cp = {m_cp[1:0], cap_in};
        m_fl = {m_fl[1:0], fault_n};
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string preq;
        preq = (m_ovr != 0) ? "R8" : (mode_pwm ? "R4" : "R5");
        chk(cur_req, "tmr_cnt", tmr_cnt, m_cnt);
        chk(preq, "tmr_out", tmr_out, exp_pin());
        chk("R8", "tmr_oe", tmr_oe, (m_ovr != 0 && m_st == 3) ? 0 : 1);
        chk("R8", "ovr_active", ovr_active, m_ovr);
        chk("R7", "cap0", cap0, m_c0);
        chk("R7", "cap1", cap1, m_c1);
        chk("R7", "irq_capture", irq_capture, m_irqc);
        chk("R2", "irq_period", irq_period, m_irqp);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #2;
        compare_all();
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cmp_wr = 0; ovr_clr = 0;
            cyc();
        end
    endtask

    task automatic wr_cmp(input int idx, input int val);
        @(negedge clk);
        cmp_wr = (idx == 0) ? 2'b01 : 2'b10;
        cmp_wdata = 16'(val);
        cyc();
        @(negedge clk);
        cmp_wr = 0;
        cyc();
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state seen at the ports
        chk("R1", "tmr_cnt", tmr_cnt, 0);
        chk("R1", "cap0", cap0, 0);
        chk("R1", "cap1", cap1, 0);
        chk("R1", "tmr_out", tmr_out, 0);
        chk("R1", "tmr_oe", tmr_oe, 1);
        chk("R1", "ovr_active", ovr_active, 0);
        chk("R1", "irq_period", irq_period, 0);
        chk("R1", "irq_capture", irq_capture, 0);

        // R4: PWM cycle 4 duty 2
        cur_req = "R2";
        mode_pwm = 1;
        wr_cmp(0, 4); wr_cmp(1, 2);
        @(negedge clk); run = 1; cyc();
        idle(14);
        // R3: new values written mid-period only apply after the wrap
        cur_req = "R3";
        wr_cmp(0, 7); wr_cmp(1, 5);
        idle(24);
        wr_cmp(1, 20); idle(18);   // duty above cycle: constant high
        wr_cmp(1, 0);  idle(18);   // duty zero: constant low
        // R5: square wave
        cur_req = "R2";
        @(negedge clk); mode_pwm = 0; cyc();
        wr_cmp(0, 3);
        idle(30);
        // R9: frozen while run is low
        cur_req = "R9";
        @(negedge clk); run = 0; cyc();
        idle(10);
        @(negedge clk); run = 1; cyc();
        // R6: external event source
        cur_req = "R6";
        @(negedge clk); clk_src = 1; cyc();
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); ev_in = $urandom_range(0, 1); cyc();
        end
        // R6: peer match with each divider
        @(negedge clk); clk_src = 2; ev_in = 0; cyc();
        for (int d = 0; d < 4; d++) begin
            @(negedge clk); peer_div = 2'(d); cyc();
            for (int i = 0; i < 90; i++) begin
                @(negedge clk); peer_match = ($urandom_range(0, 2) != 0); cyc();
            end
        end
        // R6: no tick source
        @(negedge clk); clk_src = 3; peer_match = 1; cyc();
        idle(10);
        // R7: capture on each edge selection
        cur_req = "R2";
        @(negedge clk); clk_src = 0; peer_match = 0; mode_pwm = 1; cyc();
        for (int e = 0; e < 4; e++) begin
            @(negedge clk); cap_edge = 2'(e); cyc();
            for (int i = 0; i < 50; i++) begin
                @(negedge clk); cap_in = ($urandom_range(0, 3) == 0) ? ~cap_in : cap_in; cyc();
            end
        end
        // R8: each override level, ignored with selection 0
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); ovr_sel = 2'(s); fault_n = 0; cyc();
            idle(8);
            @(negedge clk); fault_n = 1; cyc();
            idle(4);
            @(negedge clk); ovr_clr = 1; cyc();
            idle(4);
        end
        // R8: fault edge and clear in the same cycle, fault wins
        @(negedge clk); ovr_sel = 2; fault_n = 0; cyc();
        idle(1);
        @(negedge clk); ovr_clr = 1; cyc();
        idle(5);
        @(negedge clk); fault_n = 1; ovr_clr = 1; cyc();
        idle(5);

        // constrained random mix
        cur_req = "R2";
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            run       = ($urandom_range(0, 15) != 0);
            if ($urandom_range(0, 63) == 0) mode_pwm = ~mode_pwm;
            if ($urandom_range(0, 127) == 0) clk_src = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 127) == 0) peer_div = 2'($urandom_range(0, 3));
            ev_in      = $urandom_range(0, 1);
            peer_match = $urandom_range(0, 1);
            cmp_wr     = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            cmp_wdata  = 16'($urandom_range(0, 12));
            if ($urandom_range(0, 31) == 0) cap_edge = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) cap_in = ~cap_in;
            if ($urandom_range(0, 40) == 0) fault_n = ~fault_n;
            ovr_sel    = 2'($urandom_range(0, 3));
            ovr_clr    = ($urandom_range(0, 30) == 0);
            cyc();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule